// File: doc/BRIEF.md
# Single-Approach Four-Way Signal Sequencer

This block sequences the signal heads of a four-way crossing so that only one approach has the right of way at any moment. Each approach (north, east, south, west) has a through head and a protected left-turn head. Right turns have no head. An approach is served with a through green, a through amber, a left-turn green and a left-turn amber. The four approaches are then served in turn and the sequence repeats without end. All heads that are not being served show red.

Timing comes from one seconds down-counter. An external strobe, one clock wide and once per second, drives it. The counter is loaded with the length of the next interval at each phase change. A phase is left only once the counter has reached zero. After reset the block holds a one-cycle start-up state, with amber on the through heads and red on the left-turn heads, and then opens the first green. The current phase number and the seconds still to run are brought out beside the lamps.

Top module: `solo_signal_seq`

## Requirements
- R1: After reset, the block is in the start-up state for exactly one cycle. In that state `phase_o` = 16, `remain_o` = 0, every through head shows amber and every left head shows red. The next cycle is phase 0.
- R2: Phase k (0..15) serves approach k/4, where 0 = north, 1 = east, 2 = south and 3 = west. Its step is k%4: 0 = through green, 1 = through amber, 2 = left green, 3 = left amber. Phases advance k to k+1, and 15 wraps to 0, never back to start-up.
- R3: Each head is a 3-bit field. Approach a occupies bits [3a+2:3a] of `thru_lamps_o` and `left_lamps_o`, with bit 0 green, bit 1 amber and bit 2 red. In phase k only the served head shows green or amber, and the other seven heads show red. Every head has exactly one lamp lit.
- R4: When a phase is entered, `remain_o` is loaded with GREEN_SEC (20) for a green phase or AMBER_SEC (3) for an amber phase. With ticks at least two cycles apart, exactly that many ticks fall inside the phase.
- R5: While `remain_o` is non-zero the phase holds and each tick lowers `remain_o` by one. The phase advances on the clock edge that follows the cycle in which `remain_o` reads zero, whether or not a tick is present.
- R6: A tick that arrives in the zero-count cycle is absorbed by the reload. With a tick in every cycle, each phase spans its length plus one tick.
- R7: One full rotation through the sixteen phases takes 184 ticks when ticks are spaced, and 200 ticks when a tick arrives in every cycle.
- R8: Outside start-up, at most one head across all eight shows green or amber.
- R9: Asserting the synchronous `rst` at any point returns the block to the start-up state at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle strobe, once per second |
| thru_lamps_o | output | 12 | Through heads, 3 bits per approach (red, amber, green) |
| left_lamps_o | output | 12 | Left-turn heads, 3 bits per approach (red, amber, green) |
| phase_o | output | 5 | Current phase 0..15; 16 in start-up |
| remain_o | output | 5 | Seconds left in the current phase |

## Verification
The hardest case to reach is a tick that lands in the very cycle in which the counter sits at zero. Spaced ticks never produce it. The stimulus therefore switches to a tick in every cycle for a stretch, so that every phase boundary meets a colliding tick, and the bench checks that each phase gains exactly one tick and that the rotation grows to 200 ticks. A reset pulse in the middle of a phase is followed by irregular tick gaps of two to five cycles. This tests that the phase lengths are counted in ticks and not in clock cycles.

// File: rtl/sigseq_pkg.sv
package sigseq_pkg;

  localparam int N_APPR         = 4;
  localparam int STEPS_PER_APPR = 4;
  localparam int N_PHASE        = N_APPR * STEPS_PER_APPR;
  localparam int PH_W           = $clog2(N_PHASE + 1);
  localparam int ST_W           = N_PHASE + 1;
  localparam int LAMP_W         = 3 * N_APPR;
  localparam logic [PH_W-1:0] STARTUP_IDX = PH_W'(N_PHASE);

  typedef struct packed {
    logic red;
    logic amber;
    logic green;
  } head_t;

  localparam head_t HEAD_RED   = '{red: 1'b1, amber: 1'b0, green: 1'b0};
  localparam head_t HEAD_AMBER = '{red: 1'b0, amber: 1'b1, green: 1'b0};
  localparam head_t HEAD_GREEN = '{red: 1'b0, amber: 1'b0, green: 1'b1};

  // approach served by a phase
  function automatic int phase_owner(input logic [PH_W-1:0] ph);
    return int'(ph) / STEPS_PER_APPR;
  endfunction

  // second half of an approach's steps belongs to the left-turn head
  function automatic logic phase_is_left(input logic [PH_W-1:0] ph);
    return (int'(ph) % STEPS_PER_APPR) >= (STEPS_PER_APPR / 2);
  endfunction

  // odd steps are the clearance interval
  function automatic logic phase_is_amber(input logic [PH_W-1:0] ph);
    return (int'(ph) % 2) == 1;
  endfunction

  function automatic int phase_secs(input logic [PH_W-1:0] ph,
                                    input int green_s, input int amber_s);
    return phase_is_amber(ph) ? amber_s : green_s;
  endfunction

  function automatic logic [PH_W-1:0] phase_after(input logic [PH_W-1:0] ph);
    if (int'(ph) >= N_PHASE - 1) return '0;
    return ph + 1'b1;
  endfunction

endpackage

// File: rtl/sigseq_timer.sv
module sigseq_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_o
);

  assign zero_o = (count_o == '0);

  // reload wins over a coincident tick; the counter never wraps below zero
  always_ff @(posedge clk) begin
    if (rst)                  count_o <= '0;
    else if (load_i)          count_o <= load_val_i;
    else if (tick_i && !zero_o) count_o <= count_o - 1'b1;
  end

endmodule

// File: rtl/sigseq_fsm.sv
module sigseq_fsm
  import sigseq_pkg::*;
#(
  parameter int GREEN_SEC = 20,
  parameter int AMBER_SEC = 3,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zero_i,
  output logic [PH_W-1:0]  phase_o,
  output logic             start_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o
);

  // bit 0 = start-up, bit k+1 = phase k
  logic [ST_W-1:0] state_q, state_d;
  logic            legal;
  logic [PH_W-1:0] next_ph;

  assign legal   = $onehot(state_q);
  assign start_o = state_q[0];
  assign next_ph = phase_after(phase_o);

  always_comb begin
    phase_o = '0;
    for (int k = 0; k < N_PHASE; k++) begin
      if (state_q[k+1]) phase_o = phase_o | PH_W'(k);
    end
    if (state_q[0]) phase_o = phase_o | STARTUP_IDX;
  end

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    if (!legal) begin
      state_d = ST_W'(1);
    end else if (state_q[0]) begin
      state_d    = ST_W'(2);
      load_o     = 1'b1;
      load_val_o = CNT_W'(GREEN_SEC);
    end else if (zero_i) begin
      state_d    = {state_q[ST_W-2:1], state_q[ST_W-1], 1'b0};
      load_o     = 1'b1;
      load_val_o = CNT_W'(phase_secs(next_ph, GREEN_SEC, AMBER_SEC));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_W'(1);
    else     state_q <= state_d;
  end

endmodule

// File: rtl/sigseq_lamps.sv
module sigseq_lamps
  import sigseq_pkg::*;
(
  input  logic [PH_W-1:0]   phase_i,
  input  logic              start_i,
  output logic [LAMP_W-1:0] thru_o,
  output logic [LAMP_W-1:0] left_o
);

  for (genvar a = 0; a < N_APPR; a++) begin : g_appr
    head_t thru_h, left_h;
    always_comb begin
      thru_h = HEAD_RED;
      left_h = HEAD_RED;
      if (start_i) begin
        thru_h = HEAD_AMBER;
      end else if (phase_owner(phase_i) == a) begin
        if (phase_is_left(phase_i))
          left_h = phase_is_amber(phase_i) ? HEAD_AMBER : HEAD_GREEN;
        else
          thru_h = phase_is_amber(phase_i) ? HEAD_AMBER : HEAD_GREEN;
      end
    end
    assign thru_o[3*a +: 3] = thru_h;
    assign left_o[3*a +: 3] = left_h;
  end

endmodule

// File: rtl/solo_signal_seq.sv
module solo_signal_seq
  import sigseq_pkg::*;
#(
  parameter int GREEN_SEC = 20,
  parameter int AMBER_SEC = 3,
  localparam int CNT_W = $clog2(((GREEN_SEC > AMBER_SEC) ? GREEN_SEC : AMBER_SEC) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  output logic [LAMP_W-1:0] thru_lamps_o,
  output logic [LAMP_W-1:0] left_lamps_o,
  output logic [PH_W-1:0]   phase_o,
  output logic [CNT_W-1:0]  remain_o
);

  // internal events, named for the checker
  logic             phase_adv;
  logic             cnt_zero;
  logic             in_startup;
  logic [CNT_W-1:0] reload_val;

  sigseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .load_i     (phase_adv),
    .load_val_i (reload_val),
    .count_o    (remain_o),
    .zero_o     (cnt_zero)
  );

  sigseq_fsm #(
    .GREEN_SEC (GREEN_SEC),
    .AMBER_SEC (AMBER_SEC),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .zero_i     (cnt_zero),
    .phase_o    (phase_o),
    .start_o    (in_startup),
    .load_o     (phase_adv),
    .load_val_o (reload_val)
  );

  sigseq_lamps u_lamps (
    .phase_i (phase_o),
    .start_i (in_startup),
    .thru_o  (thru_lamps_o),
    .left_o  (left_lamps_o)
  );

endmodule

// File: rtl/sigseq_check.sv
module sigseq_check
  import sigseq_pkg::*;
#(
  parameter int GREEN_SEC = 20,
  parameter int AMBER_SEC = 3,
  parameter int CNT_W     = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_i,
  input logic [LAMP_W-1:0] thru_lamps_o,
  input logic [LAMP_W-1:0] left_lamps_o,
  input logic [PH_W-1:0]   phase_o,
  input logic [CNT_W-1:0]  remain_o,
  input logic              phase_adv,
  input logic              cnt_zero
);

  logic [2*N_APPR-1:0] moving;
  always_comb begin
    for (int a = 0; a < N_APPR; a++) begin
      moving[2*a]   = thru_lamps_o[3*a] | thru_lamps_o[3*a+1];
      moving[2*a+1] = left_lamps_o[3*a] | left_lamps_o[3*a+1];
    end
  end

  AST_STARTUP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    phase_o == STARTUP_IDX |=> phase_o == '0); // R1

  AST_STARTUP_LAMPS: assert property (@(posedge clk) disable iff (rst)
    phase_o == STARTUP_IDX |-> (thru_lamps_o == {N_APPR{3'b010}} &&
                                left_lamps_o == {N_APPR{3'b100}} &&
                                remain_o == '0)); // R1

  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (rst)
    (phase_o != STARTUP_IDX && cnt_zero) |=> phase_o == phase_after($past(phase_o))); // R2

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (phase_o != STARTUP_IDX && !cnt_zero) |=> $stable(phase_o)); // R5

  AST_RELOAD_LEN: assert property (@(posedge clk) disable iff (rst)
    phase_adv |=> int'(remain_o) == phase_secs(phase_o, GREEN_SEC, AMBER_SEC)); // R4

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!phase_adv && tick_i && !cnt_zero) |=> remain_o == $past(remain_o) - 1'b1); // R5

  AST_ZERO_TICK_ABSORBED: assert property (@(posedge clk) disable iff (rst)
    (phase_o != STARTUP_IDX && cnt_zero && tick_i)
      |=> int'(remain_o) == phase_secs(phase_o, GREEN_SEC, AMBER_SEC)); // R6

  AST_NO_CONFLICT: assert property (@(posedge clk) disable iff (rst)
    phase_o != STARTUP_IDX |-> $countones(moving) <= 1); // R8

  AST_RESET_STARTUP: assert property (@(posedge clk)
    rst |=> phase_o == STARTUP_IDX); // R9

  for (genvar a = 0; a < N_APPR; a++) begin : g_head
    AST_THRU_ONE_LAMP: assert property (@(posedge clk) disable iff (rst)
      $onehot(thru_lamps_o[3*a +: 3])); // R3
    AST_LEFT_ONE_LAMP: assert property (@(posedge clk) disable iff (rst)
      $onehot(left_lamps_o[3*a +: 3])); // R3
  end

endmodule

bind solo_signal_seq sigseq_check #(
  .GREEN_SEC (GREEN_SEC),
  .AMBER_SEC (AMBER_SEC),
  .CNT_W     (CNT_W)
) u_check (
  .clk          (clk),
  .rst          (rst),
  .tick_i       (tick_i),
  .thru_lamps_o (thru_lamps_o),
  .left_lamps_o (left_lamps_o),
  .phase_o      (phase_o),
  .remain_o     (remain_o),
  .phase_adv    (phase_adv),
  .cnt_zero     (cnt_zero)
);

// File: tb/solo_signal_seq_test.sv
`timescale 1ns/1ps
module solo_signal_seq_test;
  localparam int GS = 20, AS = 3, NPH = 16, START = 16;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic [11:0] thru, left;
  logic [4:0]  ph, rem;

  solo_signal_seq #(.GREEN_SEC(GS), .AMBER_SEC(AS)) uut (
    .clk(clk), .rst(rst), .tick_i(tick),
    .thru_lamps_o(thru), .left_lamps_o(left),
    .phase_o(ph), .remain_o(rem));

  always #2.5 clk = ~clk;

  int vectors = 0, errors = 0;
  int m_ph = START, m_rem = 0;
  int mode = 1, gap = 0;
  bit last_tick = 0, prev_rst = 1, done = 0;
  logic [15:0] lfsr = 16'hACE1;
  int prev_obs = START, ph_ticks = 0, cyc_ticks = 0, cycles_seen = 0;
  bit ph_valid = 0, cyc_valid = 0;

  function automatic int len_of(int p);
    return (p % 2 == 1) ? AS : GS;
  endfunction

  // R3 encoding: bit0 green, bit1 amber, bit2 red
  function automatic logic [2:0] exp_head(int p, int a, bit lt);
    if (p == START) return lt ? 3'b100 : 3'b010;
    if (p / 4 != a) return 3'b100;
    if (((p % 4) >= 2) != lt) return 3'b100;
    return (p % 2 == 1) ? 3'b010 : 3'b001;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit rst_v);
    int obs, go, e;
    bit tn;
    logic [11:0] et, el;
    string tag;
    @(negedge clk);
    obs = int'(ph);
    tag = prev_rst ? "R9" : ((m_ph == START) ? "R1" : "R2");
    chk(obs == m_ph, tag, "phase", obs, m_ph);
    chk(int'(rem) == m_rem, (m_ph == START) ? "R1" : "R5", "remaining", int'(rem), m_rem);
    for (int a = 0; a < 4; a++) begin
      et[3*a +: 3] = exp_head(m_ph, a, 1'b0);
      el[3*a +: 3] = exp_head(m_ph, a, 1'b1);
    end
    chk(thru == et, (m_ph == START) ? "R1" : "R3", "through lamps", int'(thru), int'(et));
    chk(left == el, (m_ph == START) ? "R1" : "R3", "left lamps", int'(left), int'(el));
    if (obs != START) begin
      go = 0;
      for (int a = 0; a < 4; a++)
        go += int'(thru[3*a] | thru[3*a+1]) + int'(left[3*a] | left[3*a+1]);
      chk(go <= 1, "R8", "heads moving at once", go, 1);
    end
    // per-phase and per-rotation tick accounting from observed phase
    if (obs != prev_obs) begin
      if (ph_valid && prev_obs != START) begin
        e = len_of(prev_obs) + ((mode == 0) ? 1 : 0);
        chk(ph_ticks == e, (mode == 0) ? "R6" : "R4", "ticks in phase", ph_ticks, e);
      end
      if (cyc_valid && prev_obs == NPH - 1 && obs == 0) begin
        e = 184 + ((mode == 0) ? 16 : 0);
        chk(cyc_ticks == e, "R7", "ticks per rotation", cyc_ticks, e);
        cycles_seen++;
      end
      ph_ticks = 0;
      ph_valid = 1;
      if (obs == 0) begin cyc_ticks = 0; cyc_valid = 1; end
    end
    prev_obs = obs;
    // choose the tick for the coming edge
    case (mode)
      0: tn = 1'b1;
      1: tn = !last_tick;
      default: begin
        if (gap == 0) begin
          tn = 1'b1;
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          gap = 1 + int'(lfsr[1:0]);
        end else begin
          tn = 1'b0;
          gap--;
        end
      end
    endcase
    last_tick = tn;
    tick = tn;
    rst = rst_v;
    prev_rst = rst_v;
    if (rst_v) begin ph_valid = 0; cyc_valid = 0; end
    else if (obs != START && tn) begin ph_ticks++; cyc_ticks++; end
    // reference model for the coming edge
    if (rst_v) begin m_ph = START; m_rem = 0; end
    else if (m_ph == START) begin m_ph = 0; m_rem = GS; end
    else if (m_rem == 0) begin m_ph = (m_ph + 1) % NPH; m_rem = len_of(m_ph); end
    else if (tn) m_rem--;
  endtask

  initial begin
    repeat (3) step(1'b1);
    mode = 1;
    repeat (800) step(1'b0);
    mode = 0; ph_valid = 0; cyc_valid = 0;            // R6 colliding ticks
    repeat (450) step(1'b0);
    mode = 2; ph_valid = 0; cyc_valid = 0;
    repeat (300) step(1'b0);
    repeat (2) step(1'b1);                            // R9 mid-phase reset
    repeat (2800) step(1'b0);
    chk(cycles_seen >= 4, "R7", "full rotations observed", cycles_seen, 4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule